// File: doc/BRIEF.md
# Serial Port Register Front-End

This block holds the register file and status logic of a simple serial port as a processor sees it over a 32-bit memory-mapped read/write bus. Seven word registers share a 13-bit (0x2000-byte) decode window. Received bytes arrive over a valid/ready handshake, and transmitted bytes leave as a one-cycle strobe. One level-sensitive interrupt line tells software that a received byte is waiting. Transmission completes at once, so the transmit flags are bookkeeping only: no bit shifting, baud generation, framing, parity or buffering happens here.

The status flags follow a small set of deliberate rules. A status write with a small value overwrites the register but keeps transmit-empty forced on. A larger value is ANDed into it. A data write only transmits below a threshold. A received byte is latched even when reception is disabled. The baud, second control, third control and guard-time words are plain storage.

Top module: `serport_regs`

## Requirements
- R1: After a synchronous reset, irq is 0, rx_ready is 1, status (offset 0x00) reads 0x000000C0 (transmit-empty bit 7 and transmit-complete bit 6 set), and every other register reads 0.
- R2: rx_ready is 1 exactly while receive-not-empty (status bit 5) is clear. A byte offered while rx_ready is 1 is accepted and always stored in the data register (offset 0x04).
- R3: An accepted byte sets receive-not-empty only when port-enable (control1 bit 13) and receiver-enable (control1 bit 2) are both 1. Otherwise the flag and irq are left unchanged.
- R4: When a byte is accepted with reception enabled and receive-interrupt-enable (control1 bit 5) set, irq is 1 from the next cycle.
- R5: A read of offset 0x04 returns the stored byte zero-extended and masked to 10 bits. It clears receive-not-empty and lowers irq.
- R6: A write of offset 0x00 with a value of 0x3FF or less loads that value ORed with 0x80. A larger value (0x400 and up) is ANDed into the current status. After the write, irq is lowered if bit 5 is clear. A status write never raises irq.
- R7: A write of offset 0x04 with a value below 0xF000 pulses tx_strobe for one cycle with tx_byte equal to the value's low 8 bits and sets status bit 6. Larger values do nothing. A data write never changes the stored receive byte.
- R8: A write of control1 (offset 0x0C) with bit 5 set, while status bit 5 is already 1, raises irq on the next cycle.
- R9: Control1 (0x0C), baud (0x08), control2 (0x10), control3 (0x14) and guard-time (0x18) read back exactly the last 32-bit value written.
- R10: An address that is not one of the seven word-aligned offsets reads 0, and a write to it changes no register. This includes any address with bits 1:0 nonzero.
- R11: bus_rdata and bus_rvalid are registered. Read data appears with bus_rvalid=1 one cycle after bus_rd_en and reflects the register state before that edge.
- R12: When a byte is accepted in the same cycle as a data read or a status write, the reception wins. The read returns the previous byte, and receive-not-empty and irq end as R3 and R4 set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (13) | Byte address within the decode window |
| bus_wr_en | input | 1 | Write request this cycle |
| bus_rd_en | input | 1 | Read request this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | bus_rdata valid, one cycle after bus_rd_en |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | RX_W (8) | Received byte |
| rx_ready | output | 1 | Receive byte accepted when high with rx_valid |
| tx_strobe | output | 1 | One-cycle transmit pulse |
| tx_byte | output | TX_W (8) | Transmitted byte, valid with tx_strobe |
| irq | output | 1 | Level interrupt, receive byte waiting |

## Verification
Two of this block's functions can land on the same clock edge: accepting a received byte, and a bus access that clears receive-not-empty. That access is either a data-register read or a small status write. The bench provokes both collisions by raising rx_valid in the same cycle as the bus request while the flag is clear. It then judges the outcome from the ports. The read must return the earlier byte, rx_ready must drop, and irq must rise. A follow-up status read and data read must show the flag set and the new byte stored.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int REG_N      = 7;
  localparam int REG_W      = 32;
  localparam int IDX_STAT   = 0;
  localparam int IDX_DATA   = 1;
  localparam int IDX_BAUD   = 2;
  localparam int IDX_CTL1   = 3;
  localparam int IDX_CTL2   = 4;
  localparam int IDX_CTL3   = 5;
  localparam int IDX_GUARD  = 6;
  localparam int PLAIN_BASE = IDX_BAUD;
  localparam int PLAIN_N    = REG_N - PLAIN_BASE;

  localparam int BIT_RXNE = 5;
  localparam int BIT_TC   = 6;
  localparam int BIT_TXE  = 7;
  localparam int BIT_RXEN = 2;
  localparam int BIT_RXIE = 5;
  localparam int BIT_PEN  = 13;

  localparam logic [REG_W-1:0] STAT_RST       = 32'h0000_00C0;
  localparam logic [REG_W-1:0] STAT_SMALL_MAX = 32'h0000_03FF;
  localparam logic [REG_W-1:0] TX_LIMIT       = 32'h0000_F000;
  localparam logic [REG_W-1:0] DATA_RD_MASK   = 32'h0000_03FF;

  typedef struct packed {
    logic pen;
    logic rxen;
    logic rxie;
  } rx_ctl_t;
endpackage

// File: rtl/serport_decode.sv
module serport_decode #(
  parameter int ADDR_W = 13,
  parameter int REG_N  = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [REG_N-1:0]  sel
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  generate
    for (genvar k = 0; k < REG_N; k++) begin : g_sel
      assign sel[k] = aligned && (word == WORD_W'(k));
    end
  endgenerate
endmodule

// File: rtl/serport_plain.sv
module serport_plain #(
  parameter int N = 5,
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        we,
  input  logic [W-1:0]        wdata,
  output logic [N-1:0][W-1:0] q
);
  generate
    for (genvar k = 0; k < N; k++) begin : g_reg
      logic [W-1:0] r;
      always_ff @(posedge clk) begin
        if (rst)        r <= '0;
        else if (we[k]) r <= wdata;
      end
      assign q[k] = r;
    end
  endgenerate
endmodule

// File: rtl/serport_flags.sv
module serport_flags
  import serport_pkg::*;
#(
  parameter int RX_W = 8,
  parameter int TX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             sel_stat,
  input  logic             sel_data,
  input  logic             sel_ctl1,
  input  logic [REG_W-1:0] wdata,
  input  rx_ctl_t          ctl,
  input  logic             rx_valid,
  input  logic [RX_W-1:0]  rx_data,
  output logic             rx_ready,
  output logic [REG_W-1:0] stat_q,
  output logic [RX_W-1:0]  data_q,
  output logic             irq,
  output logic             tx_strobe,
  output logic [TX_W-1:0]  tx_byte
);
  logic [REG_W-1:0] stat_n;
  logic [RX_W-1:0]  data_n;
  logic             irq_n;
  logic             tx_strobe_n;
  logic [TX_W-1:0]  tx_byte_n;
  logic             rx_acc;
  logic             rx_on;

  assign rx_ready = !stat_q[BIT_RXNE];
  assign rx_acc   = rx_valid && rx_ready;
  assign rx_on    = ctl.pen && ctl.rxen;

  always_comb begin
    stat_n      = stat_q;
    data_n      = data_q;
    irq_n       = irq;
    tx_strobe_n = 1'b0;
    tx_byte_n   = tx_byte;

    // status write: small values replace with transmit-empty kept, large ones mask
    if (wr_en && sel_stat) begin
      if (wdata <= STAT_SMALL_MAX) stat_n = wdata | (REG_W'(1) << BIT_TXE);
      else                         stat_n = stat_q & wdata;
      if (!stat_n[BIT_RXNE]) irq_n = 1'b0;
    end

    // data write below the limit transmits at once
    if (wr_en && sel_data && (wdata < TX_LIMIT)) begin
      stat_n[BIT_TC] = 1'b1;
      tx_strobe_n    = 1'b1;
      tx_byte_n      = wdata[TX_W-1:0];
    end

    // data read consumes the waiting byte
    if (rd_en && sel_data) begin
      stat_n[BIT_RXNE] = 1'b0;
      irq_n            = 1'b0;
    end

    // enabling the receive interrupt with a byte already waiting
    if (wr_en && sel_ctl1 && wdata[BIT_RXIE] && stat_q[BIT_RXNE])
      irq_n = 1'b1;

    // reception is applied last so it wins over same-cycle clears
    if (rx_acc) begin
      data_n = rx_data;
      if (rx_on) begin
        stat_n[BIT_RXNE] = 1'b1;
        if (ctl.rxie) irq_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q    <= STAT_RST;
      data_q    <= '0;
      irq       <= 1'b0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
    end else begin
      stat_q    <= stat_n;
      data_q    <= data_n;
      irq       <= irq_n;
      tx_strobe <= tx_strobe_n;
      tx_byte   <= tx_byte_n;
    end
  end
endmodule

// File: rtl/serport_regs.sv
module serport_regs
  import serport_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RX_W   = 8,
  parameter int TX_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic              rx_valid,
  input  logic [RX_W-1:0]   rx_data,
  output logic              rx_ready,
  output logic              tx_strobe,
  output logic [TX_W-1:0]   tx_byte,
  output logic              irq
);
  logic [REG_N-1:0]              sel;
  logic [PLAIN_N-1:0]            plain_we;
  logic [PLAIN_N-1:0][REG_W-1:0] plain_q;
  logic [REG_W-1:0]              stat_q;
  logic [RX_W-1:0]               data_q;
  logic [REG_W-1:0]              ctl1_q;
  logic [REG_W-1:0]              rd_mux;
  rx_ctl_t                       ctl;

  serport_decode #(.ADDR_W(ADDR_W), .REG_N(REG_N)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  generate
    for (genvar k = 0; k < PLAIN_N; k++) begin : g_we
      assign plain_we[k] = bus_wr_en && sel[PLAIN_BASE + k];
    end
  endgenerate

  serport_plain #(.N(PLAIN_N), .W(REG_W)) u_plain (
    .clk   (clk),
    .rst   (rst),
    .we    (plain_we),
    .wdata (bus_wdata),
    .q     (plain_q)
  );

  assign ctl1_q   = plain_q[IDX_CTL1 - PLAIN_BASE];
  assign ctl.pen  = ctl1_q[BIT_PEN];
  assign ctl.rxen = ctl1_q[BIT_RXEN];
  assign ctl.rxie = ctl1_q[BIT_RXIE];

  serport_flags #(.RX_W(RX_W), .TX_W(TX_W)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .sel_stat  (sel[IDX_STAT]),
    .sel_data  (sel[IDX_DATA]),
    .sel_ctl1  (sel[IDX_CTL1]),
    .wdata     (bus_wdata),
    .ctl       (ctl),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .rx_ready  (rx_ready),
    .stat_q    (stat_q),
    .data_q    (data_q),
    .irq       (irq),
    .tx_strobe (tx_strobe),
    .tx_byte   (tx_byte)
  );

  always_comb begin
    rd_mux = '0;
    if (sel[IDX_STAT]) rd_mux = stat_q;
    if (sel[IDX_DATA]) rd_mux = REG_W'(data_q) & DATA_RD_MASK;
    for (int k = 0; k < PLAIN_N; k++) begin
      if (sel[PLAIN_BASE + k]) rd_mux = plain_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd_en;
      if (bus_rd_en) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/serport_chk.sv
module serport_chk #(
  parameter int ADDR_W = 13,
  parameter int RX_W   = 8,
  parameter int TX_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr_en,
  input logic              bus_rd_en,
  input logic [31:0]       bus_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_strobe,
  input logic [TX_W-1:0]   tx_byte,
  input logic              irq,
  input logic [31:0]       status_q,
  input logic [31:0]       ctl1_q
);
  logic at_stat, at_data, at_ctl1, acc, rx_en, tx_req;

  assign at_stat = (bus_addr == ADDR_W'(0));
  assign at_data = (bus_addr == ADDR_W'(4));
  assign at_ctl1 = (bus_addr == ADDR_W'(12));
  assign acc     = rx_valid && rx_ready;
  assign rx_en   = ctl1_q[13] && ctl1_q[2];
  assign tx_req  = bus_wr_en && at_data && (bus_wdata < 32'h0000_F000);

  // R4
  rx_irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    acc && rx_en && ctl1_q[5] |=> irq);

  // R3
  rx_drop_chk: assert property (@(posedge clk) disable iff (rst)
    acc && !rx_en && !bus_wr_en && !bus_rd_en |=> rx_ready && $stable(irq));

  // R5
  data_rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd_en && at_data && !acc && !bus_wr_en |=> !irq && rx_ready);

  // R7
  tx_emit_chk: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> tx_strobe && (tx_byte == $past(bus_wdata[TX_W-1:0])));

  // R7
  tx_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_req |=> !tx_strobe);

  // R6
  txe_kept_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr_en && at_stat && (bus_wdata <= 32'h0000_03FF) |=> status_q[7]);

  // R8
  ctl1_irq_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr_en && at_ctl1 && bus_wdata[5] && status_q[5] |=> irq);
endmodule

bind serport_regs serport_chk #(.ADDR_W(ADDR_W), .RX_W(RX_W), .TX_W(TX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr_en (bus_wr_en),
  .bus_rd_en (bus_rd_en),
  .bus_wdata (bus_wdata),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .tx_strobe (tx_strobe),
  .tx_byte   (tx_byte),
  .irq       (irq),
  .status_q  (stat_q),
  .ctl1_q    (ctl1_q)
);

// File: tb/serport_regs_tb_top.sv
`timescale 1ns/1ps
module serport_regs_tb_top;
  localparam logic [12:0] A_STAT = 13'h000, A_DATA = 13'h004, A_BAUD = 13'h008,
                          A_CTL1 = 13'h00C, A_CTL2 = 13'h010, A_CTL3 = 13'h014,
                          A_GRD  = 13'h018;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] bus_addr = '0;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];

  always #2.5 clk = ~clk;

  serport_regs dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    @(negedge clk);
    bus_rd_en = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pins(input logic exp_irq, input logic exp_rdy, input string tag);
    check(irq == exp_irq, {tag, " irq"}, 32'(irq), 32'(exp_irq));
    check(rx_ready == exp_rdy, {tag, " rx_ready"}, 32'(rx_ready), 32'(exp_rdy));
  endtask

  // read monitor (scoreboard)
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (rd_exp_q.size() == 0) begin
        check(1'b0, "R11 unexpected rvalid", 32'(bus_rvalid), 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = rd_exp_q.pop_front();
        t = rd_tag_q.pop_front();
        check(bus_rdata == e, t, bus_rdata, e);
      end
    end
  end

  // transmit monitor
  always @(negedge clk) begin
    if (!rst && tx_strobe) begin
      if (tx_exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected tx_strobe", 32'(tx_byte), 32'h0);
      end else begin
        logic [7:0] e;
        e = tx_exp_q.pop_front();
        check(tx_byte == e, "R7 tx_byte", 32'(tx_byte), 32'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    pins(1'b0, 1'b1, "R1 reset");
    rd(A_STAT, 32'h0000_00C0, "R1 status reset");
    rd(A_BAUD, 32'h0, "R1 baud reset");
    rd(A_CTL1, 32'h0, "R1 ctl1 reset");
    rd(A_DATA, 32'h0, "R1 data reset");

    // R9 plain storage
    wr(A_BAUD, 32'h0001_A2B3);
    wr(A_CTL2, 32'hDEAD_BEEF);
    wr(A_CTL3, 32'h0F0F_0001);
    wr(A_GRD,  32'h0000_1234);
    rd(A_BAUD, 32'h0001_A2B3, "R9 baud");
    rd(A_CTL2, 32'hDEAD_BEEF, "R9 ctl2");
    rd(A_CTL3, 32'h0F0F_0001, "R9 ctl3");
    rd(A_GRD,  32'h0000_1234, "R9 guard");

    // R10 unmapped
    wr(13'h01C, 32'hFFFF_FFFF);
    wr(13'h00A, 32'h0000_5555);
    rd(13'h01C, 32'h0, "R10 unmapped 0x1C");
    rd(13'h1FFC, 32'h0, "R10 unmapped 0x1FFC");
    rd(13'h00A, 32'h0, "R10 unaligned");
    rd(A_BAUD, 32'h0001_A2B3, "R10 baud untouched");
    rd(A_GRD,  32'h0000_1234, "R10 guard untouched");

    // R3 reception disabled: byte latched, flag untouched
    wr(A_CTL1, 32'h0000_2000);
    rx_send(8'h41);
    pins(1'b0, 1'b1, "R3 disabled rx");
    rd(A_DATA, 32'h41, "R2 byte latched when disabled");
    rd(A_STAT, 32'h0000_00C0, "R3 status unchanged");

    // R2 enabled without interrupt
    wr(A_CTL1, 32'h0000_2004);
    rx_send(8'h5A);
    pins(1'b0, 1'b0, "R2 enabled rx no irq");
    rd(A_STAT, 32'h0000_00E0, "R2 status rxne");
    rx_send(8'h33);
    rd(A_DATA, 32'h5A, "R2 held byte kept");
    pins(1'b0, 1'b1, "R5 data read clears");

    // R8 interrupt enable with byte waiting
    rx_send(8'h77);
    pins(1'b0, 1'b0, "R8 before ctl1");
    wr(A_CTL1, 32'h0000_2024);
    pins(1'b1, 1'b0, "R8 ctl1 raises irq");
    rd(A_DATA, 32'h77, "R5 data read");
    pins(1'b0, 1'b1, "R5 irq lowered");

    // R4 receive interrupt, R6 small status write
    rx_send(8'h12);
    pins(1'b1, 1'b0, "R4 rx irq");
    wr(A_STAT, 32'h0);
    pins(1'b0, 1'b1, "R6 small write clears");
    rd(A_STAT, 32'h0000_0080, "R6 txe forced");

    // R6 large writes and boundary
    wr(A_STAT, 32'h0000_03FF);
    pins(1'b0, 1'b0, "R6 0x3FF small");
    rd(A_STAT, 32'h0000_03FF, "R6 0x3FF value");
    wr(A_STAT, 32'hFFFF_FFBF);
    rd(A_STAT, 32'h0000_03BF, "R6 large and");
    wr(A_STAT, 32'hFFFF_FFDF);
    pins(1'b0, 1'b1, "R6 and clears rxne");
    rd(A_STAT, 32'h0000_039F, "R6 second and");
    wr(A_STAT, 32'h0000_0400);
    rd(A_STAT, 32'h0, "R6 0x400 is large");

    // R7 transmit
    tx_exp_q.push_back(8'hAB);
    wr(A_DATA, 32'h0000_EFAB);
    rd(A_STAT, 32'h0000_0040, "R7 tc set");
    wr(A_STAT, 32'h0);
    wr(A_DATA, 32'h0000_F000);
    rd(A_STAT, 32'h0000_0080, "R7 0xF000 ignored");
    tx_exp_q.push_back(8'hFF);
    wr(A_DATA, 32'h0000_EFFF);
    rd(A_STAT, 32'h0000_00C0, "R7 0xEFFF sends");
    rd(A_DATA, 32'h12, "R7 rx byte not overwritten");

    // R12 reception meets data read
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h9C;
    bus_rd_en = 1'b1; bus_addr = A_DATA;
    rd_exp_q.push_back(32'h12); rd_tag_q.push_back("R12 read returns old byte");
    @(negedge clk);
    rx_valid = 1'b0; bus_rd_en = 1'b0;
    pins(1'b1, 1'b0, "R12 rx wins over read");
    rd(A_DATA, 32'h9C, "R12 new byte stored");
    pins(1'b0, 1'b1, "R12 after read");

    // R12 reception meets small status write
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h3C;
    bus_wr_en = 1'b1; bus_addr = A_STAT; bus_wdata = 32'h0;
    @(negedge clk);
    rx_valid = 1'b0; bus_wr_en = 1'b0;
    pins(1'b1, 1'b0, "R12 rx wins over status write");
    rd(A_STAT, 32'h0000_00A0, "R12 status after collision");
    rd(A_DATA, 32'h3C, "R12 byte after collision");

    repeat (3) @(negedge clk);
    check(bus_rvalid == 1'b0, "R11 rvalid idle", 32'(bus_rvalid), 32'h0);
    check(rd_exp_q.size() == 0, "R11 all reads answered", rd_exp_q.size(), 32'h0);
    check(tx_exp_q.size() == 0, "R7 all bytes sent", tx_exp_q.size(), 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule